// File: doc/BRIEF.md
# Programmable Scrub and Busy Scheduler

This block sets the timing of memory scrub cycles. It runs on a 20 MHz clock, so one clock is 50 ns. In master mode it raises a scrub request by itself at a programmable rate. Before each scrub it drives an active-low BUSY warning, and the time from BUSY falling to SCRUB falling is also programmable. The SCRUB and BUSY outputs let a host memory controller insert wait states, and they can also command slave memories.

In slave mode the block never schedules a scrub of its own. It watches an external active-low SCRUB line, synchronizes it, and turns each falling edge into exactly one scrub cycle. In this mode it drives neither SCRUB nor BUSY.

Two codes come from a configuration register outside the block: a 4-bit rate code and a 4-bit lead code. A one-clock scrub strobe tells the memory array when to run a correction cycle. The mode input is static and changes only while reset is held.

Top module: `scrub_sched`

## Requirements
- R1: While rst_ni is low, busy_o and scrub_o are 1 and strobe_o is 0. The first master sequence starts on the first rising edge after reset is released.
- R2: In master mode each sequence drives busy_o low first. scrub_o goes low exactly lead_code_i clocks later. strobe_o is 1 for the single clock in which scrub_o first reads low.
- R3: In master mode scrub_o stays low for exactly 5 clocks (250 ns) in each sequence.
- R4: In master mode busy_o returns to 1 exactly one clock after scrub_o returns to 1.
- R5: The rate code n sets a scrub interval of 2^n clocks, that is 20 MHz divided by 2^n. Whenever 2^n is at least lead+7 clocks, consecutive sequences start exactly 2^n clocks apart.
- R6: A request that arrives while a sequence is running is held as a single pending request. The next sequence then starts on the clock after the block returns to idle, so busy_o is high for exactly one clock between back-to-back sequences.
- R7: rate_code_i is sampled only when an interval expires. A change in mid-interval leaves the current interval unchanged and applies from the next one.
- R8: lead_code_i is sampled when a sequence starts. A change during a sequence does not alter that sequence.
- R9: In slave mode scrub_oe_o and busy_oe_o are 0 and busy_o and scrub_o read 1. The block never starts a sequence by itself. Each falling edge of scrub_i gives exactly one strobe_o pulse. If scrub_i is first sampled low at rising edge E, that pulse is seen in the clock after edge E+2.
- R10: In master mode scrub_oe_o and busy_oe_o are 1.
- R11: With lead code 0, busy_o and scrub_o fall in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 20 MHz clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master (self-scheduling), 0 = slave |
| rate_code_i | input | 4 | Scrub interval code n, interval 2^n clocks |
| lead_code_i | input | 4 | BUSY-to-SCRUB lead in clocks |
| scrub_i | input | 1 | External scrub command, active low (slave) |
| scrub_o | output | 1 | Scrub pulse, active low (master) |
| scrub_oe_o | output | 1 | Drive enable for scrub_o |
| busy_o | output | 1 | Wait-state warning, active low (master) |
| busy_oe_o | output | 1 | Drive enable for busy_o |
| strobe_o | output | 1 | One-clock scrub cycle command to the array |

## Verification
The hardest cases are the ones where a code changes while the block is busy: a rate change in the middle of an interval, and a lead change while BUSY is already low. In both the visible effect arrives one interval later and would be easy to miss. The stimulus resets into a known phase, counts edges from the release of reset, and writes the new code at a chosen cycle inside the first interval or the first lead window. The scoreboard queue holds the exact strobe cycles that follow. Rate code 0 forces every timer tick to collide with a running sequence, which exercises the merging of pending requests.

// File: rtl/scrub_sched_pkg.sv
package scrub_sched_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_LEAD  = 2'd1,
    SQ_SCRUB = 2'd2,
    SQ_TAIL  = 2'd3
  } sq_state_e;
endpackage

// File: rtl/scrub_interval_timer.sv
module scrub_interval_timer #(
  parameter int RATE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  localparam int CNT_W = 1 << RATE_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;

  // Code is sampled only at expiry, so a mid-interval change waits a period.
  assign reload = (CNT_W'(1) << rate_i) - CNT_W'(1);
  assign tick_o = en_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q == '0)   cnt_q <= reload;
    else                    cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/scrub_edge_sync.sv
module scrub_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic line_ni,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b1;
    else         sync_q[0] <= line_ni;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b1;
      else         sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign fall_o = en_i && prev_q && !sync_q[STAGES-1];

  assert_single_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/scrub_sequencer.sv
module scrub_sequencer
  import scrub_sched_pkg::*;
#(
  parameter int LEAD_W    = 4,
  parameter int SCRUB_LEN = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              skip_lead_i,
  input  logic [LEAD_W-1:0] lead_i,
  output logic              idle_o,
  output logic              busy_n_o,
  output logic              scrub_n_o,
  output logic              strobe_o
);
  localparam int LEN_W = $clog2(SCRUB_LEN);
  localparam int CW    = (LEAD_W > LEN_W) ? LEAD_W : LEN_W;

  sq_state_e       state_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (start_i) begin
          // lead is captured here; later code changes do not touch this run
          if (skip_lead_i || lead_i == '0) begin
            state_q <= SQ_SCRUB;
            cnt_q   <= CW'(SCRUB_LEN - 1);
          end else begin
            state_q <= SQ_LEAD;
            cnt_q   <= CW'(lead_i) - CW'(1);
          end
        end
        SQ_LEAD: if (cnt_q == '0) begin
          state_q <= SQ_SCRUB;
          cnt_q   <= CW'(SCRUB_LEN - 1);
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
        SQ_SCRUB: if (cnt_q == '0) state_q <= SQ_TAIL;
                  else             cnt_q   <= cnt_q - CW'(1);
        default:  state_q <= SQ_IDLE;
      endcase
    end
  end

  assign idle_o    = (state_q == SQ_IDLE);
  assign busy_n_o  = (state_q == SQ_IDLE);
  assign scrub_n_o = (state_q != SQ_SCRUB);
  assign strobe_o  = (state_q == SQ_SCRUB) && (cnt_q == CW'(SCRUB_LEN - 1));

  // checker-only low-time counter
  logic [7:0] low_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         low_cnt_q <= '0;
    else if (!scrub_n_o) low_cnt_q <= low_cnt_q + 8'd1;
    else                 low_cnt_q <= '0;
  end

  assert_scrub_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scrub_n_o) |-> (low_cnt_q == 8'(SCRUB_LEN)));
  assert_busy_tail_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scrub_n_o) |=> $rose(busy_n_o));
  assert_strobe_at_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> ($fell(scrub_n_o) && !busy_n_o));
endmodule

// File: rtl/scrub_sched.sv
module scrub_sched #(
  parameter int RATE_W      = 4,
  parameter int LEAD_W      = 4,
  parameter int SCRUB_LEN   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic [RATE_W-1:0] rate_code_i,
  input  logic [LEAD_W-1:0] lead_code_i,
  input  logic              scrub_i,
  output logic              scrub_o,
  output logic              scrub_oe_o,
  output logic              busy_o,
  output logic              busy_oe_o,
  output logic              strobe_o
);
  logic tick, fall, req, start, pending_q;
  logic idle, seq_busy_n, seq_scrub_n;

  scrub_interval_timer #(.RATE_W(RATE_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (master_i),
    .rate_i (rate_code_i),
    .tick_o (tick)
  );

  scrub_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (!master_i),
    .line_ni (scrub_i),
    .fall_o  (fall)
  );

  assign req   = tick || fall;
  assign start = idle && (req || pending_q);

  // at most one request waits while a sequence is running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pending_q <= 1'b0;
    else if (start) pending_q <= 1'b0;
    else if (req)   pending_q <= 1'b1;
  end

  scrub_sequencer #(.LEAD_W(LEAD_W), .SCRUB_LEN(SCRUB_LEN)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .skip_lead_i (!master_i),
    .lead_i      (lead_code_i),
    .idle_o      (idle),
    .busy_n_o    (seq_busy_n),
    .scrub_n_o   (seq_scrub_n),
    .strobe_o    (strobe_o)
  );

  assign scrub_o    = master_i ? seq_scrub_n : 1'b1;
  assign busy_o     = master_i ? seq_busy_n  : 1'b1;
  assign scrub_oe_o = master_i;
  assign busy_oe_o  = master_i;

  assert_slave_no_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> !tick);
  assert_master_no_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i |-> !fall);
endmodule

// File: tb/scrub_sched_bench.sv
module scrub_sched_bench;
  localparam int CLK_PERIOD = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master = 1'b1;
  logic [3:0] rate = 4'd7;
  logic [3:0] lead = 4'd10;
  logic       scrub_in = 1'b1;
  logic       scrub_o, scrub_oe, busy_o, busy_oe, strobe;

  scrub_sched u_scrub_sched (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .master_i    (master),
    .rate_code_i (rate),
    .lead_code_i (lead),
    .scrub_i     (scrub_in),
    .scrub_o     (scrub_o),
    .scrub_oe_o  (scrub_oe),
    .busy_o      (busy_o),
    .busy_oe_o   (busy_oe),
    .strobe_o    (strobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    cyc;
    int    lead;
    string req;
  } exp_t;

  exp_t  q[$];
  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  string phase_req = "R1";
  bit    b2b_chk = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // monitor / scoreboard
  bit prev_busy = 1'b1, prev_scrub = 1'b1, rise_seen = 1'b0;
  int busy_fall = 0, scrub_fall = 0, scrub_rise = 0, busy_rise = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_busy  = 1'b1;
      prev_scrub = 1'b1;
      rise_seen  = 1'b0;
    end else begin
      if (prev_busy && !busy_o) begin
        busy_fall = cyc;
        if (b2b_chk && rise_seen) chk(busy_fall - busy_rise == 1, "R6", busy_fall - busy_rise, 1);
      end
      if (prev_scrub && !scrub_o) scrub_fall = cyc;
      if (!prev_scrub && scrub_o) begin
        scrub_rise = cyc;
        chk(scrub_rise - scrub_fall == 5, "R3", scrub_rise - scrub_fall, 5);
      end
      if (!prev_busy && busy_o) begin
        busy_rise = cyc;
        rise_seen = 1'b1;
        chk(busy_rise - scrub_rise == 1, "R4", busy_rise - scrub_rise, 1);
      end
      if (strobe) begin
        if (q.size() == 0) begin
          chk(1'b0, {phase_req, " unexpected strobe"}, cyc, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc == e.cyc, e.req, cyc, e.cyc);
          if (e.lead >= 0) begin
            chk(scrub_fall == cyc, "R2", scrub_fall, cyc);
            chk(scrub_fall - busy_fall == e.lead, e.lead == 0 ? "R11" : "R2",
                scrub_fall - busy_fall, e.lead);
          end
        end
      end
      prev_busy  = busy_o;
      prev_scrub = scrub_o;
    end
  end

  task automatic do_reset(bit m, int n, int k);
    rst_n = 1'b0;
    q.delete();
    master = m;
    rate = 4'(n);
    lead = 4'(k);
    b2b_chk = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic push(int c, int l, string r);
    exp_t e;
    e.cyc = c; e.lead = l; e.req = r;
    q.push_back(e);
  endtask

  task automatic drain(string r);
    chk(q.size() == 0, {r, " missing strobes"}, q.size(), 0);
  endtask

  task automatic run_master(int n, int k, int cnt, string r);
    int p;
    p = 1 << n;
    phase_req = r;
    do_reset(1'b1, n, k);
    for (int m = 0; m < cnt; m++) push(1 + k + m * p, k, r);
    wait_until(1 + k + (cnt - 1) * p + 2);
    drain(r);
  endtask

  task automatic slave_pulse(int len);
    int c;
    c = cyc;
    scrub_in = 1'b0;
    push(c + 3, -1, "R9");
    repeat (len) @(negedge clk);
    scrub_in = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    @(negedge clk);
    chk(busy_o == 1'b1, "R1 busy", busy_o, 1);
    chk(scrub_o == 1'b1, "R1 scrub", scrub_o, 1);
    chk(strobe == 1'b0, "R1 strobe", strobe, 0);
    chk(busy_oe && scrub_oe, "R10 drive enables", {busy_oe, scrub_oe}, 3);

    // R5/R1: interval spacing, first start right after reset
    run_master(5, 3, 4, "R5");
    run_master(4, 9, 4, "R5");
    // R11: zero lead
    run_master(3, 0, 4, "R11");

    // R7: rate change mid-interval
    phase_req = "R7";
    do_reset(1'b1, 5, 2);
    push(3, 2, "R7"); push(35, 2, "R7"); push(99, 2, "R7"); push(163, 2, "R7");
    wait_until(10);
    rate = 4'd6;
    wait_until(166);
    drain("R7");

    // R8: lead change inside a running lead window
    phase_req = "R8";
    do_reset(1'b1, 5, 4);
    push(5, 4, "R8"); push(34, 1, "R8");
    wait_until(2);
    lead = 4'd1;
    wait_until(37);
    drain("R8");

    // R6: rate 0, requests merge, back-to-back sequences
    phase_req = "R6";
    do_reset(1'b1, 0, 2);
    b2b_chk = 1'b1;
    for (int m = 0; m < 4; m++) push(3 + m * 9, 2, "R6");
    wait_until(32);
    drain("R6");

    // R9: slave mode
    phase_req = "R9";
    do_reset(1'b0, 0, 5);
    @(negedge clk);
    chk(!busy_oe && !scrub_oe, "R9 drive enables", {busy_oe, scrub_oe}, 0);
    repeat (40) @(negedge clk);
    chk(busy_o == 1'b1 && scrub_o == 1'b1, "R9 idle lines", {busy_o, scrub_o}, 3);
    slave_pulse(5);
    slave_pulse(4);
    slave_pulse(8);
    chk(busy_o == 1'b1 && scrub_o == 1'b1, "R9 lines after pulses", {busy_o, scrub_o}, 3);
    drain("R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule